// File: doc/BRIEF.md
# Game status seven-segment formatter

This block turns the status fields of a dice game into four characters and scans them onto a shared four-digit seven-segment display. A mode input selects what the four positions show. Play mode shows the letter P, the player number and the two die values. Score mode shows the letter S, the player number and the two decimal digits of the remaining-stick count. End mode shows the letters E, G and P, followed by the winning player number.

One digit position is lit at a time. The scan moves one position to the right on each pulse of a slow scan enable, about 512 Hz. Segment lines and digit enables are registered together, so they change on the same clock edge.

In end mode the whole display flashes. The flash timing is counted in scan ticks, so no second timing input is needed. A blank request turns the whole display dark for as long as it is held.

Top module: `status_scan_display`

## Requirements
- R1: While reset is low, dig_n is 1111 and seg_n is all ones. At the first clock edge after reset is released, the leftmost position is lit (dig_n = 0111).
- R2: Each clock cycle with scan_tick high moves the lit position one step right, in the order 0111, 1011, 1101, 1110, then back to 0111. The position holds while scan_tick is low.
- R3: At most one bit of dig_n is low at any time. dig_n and seg_n are both registered and change on the same clock edge, one cycle after the scan position or the inputs change.
- R4: mode = 0 (play) shows, from left to right: P, player, die1, die2. A die value of 0 shows the digit 0.
- R5: mode = 1 (score) shows, from left to right: S, player, the tens digit of sticks, the ones digit of sticks (for example, 11 shows 1 then 1, and 9 shows 0 then 9).
- R6: mode = 2 (end) shows, from left to right: E, G, P, winner.
- R7: In end mode the display stays visible for FLASH_HALF scan ticks after end mode is entered. It is then dark (dig_n = 1111, seg_n all ones) for FLASH_HALF scan ticks, and the two phases keep alternating. Any other mode clears the phase, and the display is visible two cycles after end mode is left.
- R8: While blank is high, dig_n is 1111 and seg_n is all ones, from the first clock edge after blank rises. Scanning continues underneath.
- R9: Segments are active low, with seg_n[0] = a up to seg_n[6] = g.
  - Digits 0 to 9 use the usual patterns. 6 lights a, c, d, e, f, g; 7 lights a, b, c; 9 lights a, b, c, d, f, g.
  - P lights a, b, e, f, g. S lights a, c, d, f, g. E lights a, d, e, f, g. G lights a, c, d, e, f.
  - mode = 3 is unused: the enables keep scanning and all segments stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle scan enable pulse, about 512 Hz |
| blank | input | 1 | Forces the display dark while high |
| mode | input | 2 | 0 play, 1 score, 2 end, 3 unused |
| player | input | 3 | Player number shown in play and score mode |
| die1 | input | 3 | First die value |
| die2 | input | 3 | Second die value |
| sticks | input | 4 | Remaining-stick count, 0 to 15 |
| winner | input | 3 | Winning player shown in end mode |
| seg_n | output | 7 | Segments a..g, active low, bit 0 = a |
| dig_n | output | 4 | Digit enables, active low, bit 3 = leftmost |

## Verification
Play mode is tried both with nonzero dice and with both dice at zero, which separates a die that is shown from one that is suppressed. Score mode is tried with the counts 11, 10 and 9, which separates the tens and ones split from a plain copy of the low bits. End mode is held long enough to cross both flash edges, and it is also left while dark, which checks that the phase is cleared. Blank and the unused mode show that scanning continues while the output is dark or empty.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;

    localparam int NPOS  = 4;
    localparam int SEG_W = 7;
    localparam int CH_W  = 4;

    typedef enum logic [1:0] {
        MODE_PLAY  = 2'd0,
        MODE_SCORE = 2'd1,
        MODE_END   = 2'd2,
        MODE_NONE  = 2'd3
    } mode_e;

    localparam logic [CH_W-1:0] CH_P   = 4'd10;
    localparam logic [CH_W-1:0] CH_S   = 4'd11;
    localparam logic [CH_W-1:0] CH_E   = 4'd12;
    localparam logic [CH_W-1:0] CH_G   = 4'd13;
    localparam logic [CH_W-1:0] CH_OFF = 4'd15;

    typedef struct packed {
        logic [SEG_W-1:0] seg_n;
        logic [NPOS-1:0]  dig_n;
    } drive_t;

endpackage

// File: rtl/sdisp_scan.sv
module sdisp_scan #(
    parameter int IDX_W      = 2,
    parameter int FLASH_HALF = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_tick,
    input  logic             end_mode,
    output logic [IDX_W-1:0] idx_q,
    output logic             dark_q
);
    localparam int CNT_W = $clog2(FLASH_HALF + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLASH_HALF - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             dark;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scan_tick) begin
            st_d.idx = st_q.idx + 1'b1;
        end
        if (!end_mode) begin
            st_d.cnt  = '0;
            st_d.dark = 1'b0;
        end else if (scan_tick) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt  = '0;
                st_d.dark = ~st_q.dark;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q  = st_q.idx;
    assign dark_q = st_q.dark;

    // R2
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
    // R2
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(idx_q));
    // R7
    flash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !end_mode |=> !dark_q);
endmodule

// File: rtl/sdisp_charsel.sv
module sdisp_charsel
    import sdisp_pkg::*;
#(
    parameter int VAL_W   = 3,
    parameter int STICK_W = 4
) (
    input  logic [1:0]                mode,
    input  logic [VAL_W-1:0]          player,
    input  logic [VAL_W-1:0]          die1,
    input  logic [VAL_W-1:0]          die2,
    input  logic [STICK_W-1:0]        sticks,
    input  logic [VAL_W-1:0]          winner,
    output logic [NPOS-1:0][CH_W-1:0] chars
);
    logic [STICK_W-1:0] tens, ones;

    always_comb begin
        tens = STICK_W'(sticks / STICK_W'(10));
        ones = STICK_W'(sticks % STICK_W'(10));
        chars = {NPOS{CH_OFF}};
        unique case (mode_e'(mode))
            MODE_PLAY: begin
                chars[0] = CH_P;
                chars[1] = CH_W'(player);
                chars[2] = CH_W'(die1);
                chars[3] = CH_W'(die2);
            end
            MODE_SCORE: begin
                chars[0] = CH_S;
                chars[1] = CH_W'(player);
                chars[2] = CH_W'(tens);
                chars[3] = CH_W'(ones);
            end
            MODE_END: begin
                chars[0] = CH_E;
                chars[1] = CH_G;
                chars[2] = CH_P;
                chars[3] = CH_W'(winner);
            end
            default: chars = {NPOS{CH_OFF}};
        endcase
    end
endmodule

// File: rtl/sdisp_segdec.sv
module sdisp_segdec
    import sdisp_pkg::*;
(
    input  logic [CH_W-1:0]  code,
    output logic [SEG_W-1:0] seg_n
);
    logic [SEG_W-1:0] lit;

    always_comb begin
        case (code)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            CH_P:    lit = 7'h73;
            CH_S:    lit = 7'h6D;
            CH_E:    lit = 7'h79;
            CH_G:    lit = 7'h3D;
            default: lit = 7'h00;
        endcase
        seg_n = ~lit;
    end
endmodule

// File: rtl/status_scan_display.sv
module status_scan_display
    import sdisp_pkg::*;
#(
    parameter int VAL_W      = 3,
    parameter int STICK_W    = 4,
    parameter int FLASH_HALF = 51
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_tick,
    input  logic               blank,
    input  logic [1:0]         mode,
    input  logic [VAL_W-1:0]   player,
    input  logic [VAL_W-1:0]   die1,
    input  logic [VAL_W-1:0]   die2,
    input  logic [STICK_W-1:0] sticks,
    input  logic [VAL_W-1:0]   winner,
    output logic [SEG_W-1:0]   seg_n,
    output logic [NPOS-1:0]    dig_n
);
    localparam int IDX_W = $clog2(NPOS);

    logic [IDX_W-1:0]           idx_q;
    logic                       dark_q;
    logic [NPOS-1:0][CH_W-1:0]  chars;
    logic [NPOS-1:0][SEG_W-1:0] pos_seg;
    logic [NPOS-1:0]            sel_n;
    logic                       show;
    drive_t                     drv_d, drv_q;

    sdisp_scan #(.IDX_W(IDX_W), .FLASH_HALF(FLASH_HALF)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_tick(scan_tick),
        .end_mode (mode_e'(mode) == MODE_END),
        .idx_q    (idx_q),
        .dark_q   (dark_q)
    );

    sdisp_charsel #(.VAL_W(VAL_W), .STICK_W(STICK_W)) u_chars (
        .mode  (mode),
        .player(player),
        .die1  (die1),
        .die2  (die2),
        .sticks(sticks),
        .winner(winner),
        .chars (chars)
    );

    for (genvar g = 0; g < NPOS; g++) begin : g_pos
        sdisp_segdec u_dec (
            .code (chars[g]),
            .seg_n(pos_seg[g])
        );
        assign sel_n[NPOS-1-g] = (idx_q != IDX_W'(g));
    end

    always_comb begin
        show = !blank && !dark_q;
        drv_d.dig_n = show ? sel_n : '1;
        drv_d.seg_n = show ? pos_seg[idx_q] : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '1;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign seg_n = drv_q.seg_n;
    assign dig_n = drv_q.dig_n;

    // R8
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> dig_n == '1);
    // R3
    one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dig_n));
    // R7
    dark_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_n == '1) |-> (seg_n == '1));
    // R2
    tick_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !blank && mode != 2'd2) |=> ##1 (dig_n != '1 && dig_n != $past(dig_n)));
endmodule

// File: tb/status_scan_display_test.sv
module status_scan_display_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_tick = 1'b0;
    logic       blank = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] player = 3'd1;
    logic [2:0] die1 = 3'd0;
    logic [2:0] die2 = 3'd0;
    logic [3:0] sticks = 4'd11;
    logic [2:0] winner = 3'd1;
    logic [6:0] seg_n;
    logic [3:0] dig_n;

    int total = 0;
    int bad = 0;
    int bpos = 0;
    localparam int HALF = 51;

    always #2 clk = ~clk;

    status_scan_display uut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .blank(blank),
        .mode(mode), .player(player), .die1(die1), .die2(die2),
        .sticks(sticks), .winner(winner), .seg_n(seg_n), .dig_n(dig_n)
    );

    function automatic logic [6:0] bseg(int ch);
        logic [6:0] on;
        case (ch)
            0: on = 7'b0111111;  1: on = 7'b0000110;
            2: on = 7'b1011011;  3: on = 7'b1001111;
            4: on = 7'b1100110;  5: on = 7'b1101101;
            6: on = 7'b1111101;  7: on = 7'b0000111;
            8: on = 7'b1111111;  9: on = 7'b1101111;
            10: on = 7'b1110011; 11: on = 7'b1101101;
            12: on = 7'b1111001; 13: on = 7'b0111101;
            default: on = 7'b0000000;
        endcase
        return ~on;
    endfunction

    function automatic logic [3:0] bdig(int p);
        return ~(4'b1000 >> p);
    endfunction

    task automatic check(string req, logic [3:0] ed, logic [6:0] es);
        total++;
        if (dig_n !== ed || seg_n !== es) begin
            bad++;
            $display("FAIL %s: dig_n=%b seg_n=%b expected dig_n=%b seg_n=%b",
                     req, dig_n, seg_n, ed, es);
        end
    endtask

    task automatic clk1();
        @(negedge clk);
    endtask

    task automatic tick();
        scan_tick = 1'b1;
        clk1();
        scan_tick = 1'b0;
        bpos = (bpos + 1) % 4;
        clk1();
    endtask

    task automatic goto_pos(int p);
        while (bpos != p) tick();
    endtask

    task automatic check_four(string req, int c0, int c1, int c2, int c3);
        int cs[4];
        cs = '{c0, c1, c2, c3};
        for (int p = 0; p < 4; p++) begin
            goto_pos(p);
            check(req, bdig(p), bseg(cs[p]));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) clk1();
        check("R1 in reset", 4'b1111, 7'h7F);
        rst_n = 1'b1;
        clk1();
        bpos = 0;
        check("R1 first cycle", 4'b0111, bseg(10));
    endtask

    task automatic t_scan();
        repeat (5) clk1();
        check("R2 hold without tick", 4'b0111, bseg(10));
        for (int k = 1; k <= 4; k++) begin
            tick();
            check("R2/R3 step", bdig(k % 4), bseg(k % 4 == 0 ? 10 : (k % 4 == 1 ? 1 : 0)));
        end
    endtask

    task automatic t_play();
        player = 3'd2; die1 = 3'd3; die2 = 3'd5;
        clk1(); clk1();
        check_four("R4 play dice", 10, 2, 3, 5);
        player = 3'd4; die1 = 3'd0; die2 = 3'd0;
        clk1(); clk1();
        check_four("R4 play zero dice", 10, 4, 0, 0);
        player = 3'd3; die1 = 3'd6; die2 = 3'd1;
        clk1(); clk1();
        check_four("R9 digits 6 and 1", 10, 3, 6, 1);
    endtask

    task automatic t_score();
        mode = 2'd1; player = 3'd1;
        sticks = 4'd11;
        clk1(); clk1();
        check_four("R5 score 11", 11, 1, 1, 1);
        sticks = 4'd9;
        clk1(); clk1();
        check_four("R5 score 9", 11, 1, 0, 9);
        sticks = 4'd10; player = 3'd2;
        clk1(); clk1();
        check_four("R5 score 10", 11, 2, 1, 0);
        sticks = 4'd7;
        clk1(); clk1();
        check_four("R9 digit 7", 11, 2, 0, 7);
    endtask

    task automatic t_end_flash();
        winner = 3'd4;
        mode = 2'd2;
        clk1(); clk1();
        check("R6 end first char", bdig(bpos), bseg(bpos == 0 ? 12 : bpos == 1 ? 13 : bpos == 2 ? 10 : 4));
        for (int k = 0; k < HALF - 1; k++) tick();
        check("R7 still visible", bdig(bpos), bseg(bpos == 0 ? 12 : bpos == 1 ? 13 : bpos == 2 ? 10 : 4));
        tick();
        check("R7 dark phase", 4'b1111, 7'h7F);
        for (int k = 0; k < HALF - 1; k++) tick();
        check("R7 still dark", 4'b1111, 7'h7F);
        tick();
        check("R7 visible again", bdig(bpos), bseg(bpos == 0 ? 12 : bpos == 1 ? 13 : bpos == 2 ? 10 : 4));
        for (int k = 0; k < HALF; k++) tick();
        check("R7 dark second time", 4'b1111, 7'h7F);
        mode = 2'd0; player = 3'd1; die1 = 3'd2; die2 = 3'd4;
        clk1(); clk1();
        check("R7 leave end clears", bdig(bpos), bseg(bpos == 0 ? 10 : bpos == 1 ? 1 : bpos == 2 ? 2 : 4));
        mode = 2'd2;
        clk1(); clk1();
        check_four("R6 end chars", 12, 13, 10, 4);
        mode = 2'd0;
        clk1(); clk1();
    endtask

    task automatic t_blank();
        goto_pos(1);
        blank = 1'b1;
        clk1();
        check("R8 blank dark", 4'b1111, 7'h7F);
        tick(); tick();
        check("R8 blank held", 4'b1111, 7'h7F);
        blank = 1'b0;
        clk1();
        check("R8 release scans on", bdig(3), bseg(4));
    endtask

    task automatic t_unused();
        mode = 2'd3;
        clk1(); clk1();
        for (int p = 0; p < 4; p++) begin
            goto_pos(p);
            check("R9 unused mode off", bdig(p), 7'h7F);
        end
        mode = 2'd0;
        clk1(); clk1();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_scan();
        t_play();
        t_score();
        t_end_flash();
        t_blank();
        t_unused();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule